// File: doc/BRIEF.md
# Reference Clock Lock Monitor

This block decides whether an external reference clock is present and running at the rate it should. A free-running local clock of known frequency provides the timebase. The reference is brought into the local domain through a two-stage synchronizer, and its rising edges are counted over a window of a fixed number of local cycles.

At the end of each window the count is compared against a programmed expected count, widened by a tolerance of 2000 parts per million of that count. A window with no edges, or with a count outside that band, raises the lock-lost flag at once. The flag clears only after two in-tolerance windows in a row. An option bit turns the flag into a request to disable the synchronous outputs. With the option clear, those outputs keep running freely during a loss of lock.

The reference is meant to run between 10 and 100 MHz. The local clock must be more than twice as fast as the reference so that every edge survives the synchronizer. WIN_LEN and the expected count are chosen together so that the tolerance is at least one count.

Top module: `ref_lock_monitor`

## Requirements
- R1: While reset is asserted, and from reset release until two consecutive in-tolerance windows have completed, `lol` is 1.
- R2: With a steady reference whose rising-edge count per window of WIN_LEN local cycles equals `exp_count`, `lol` settles to 0 and stays 0.
- R3: A window in which no reference edge is seen sets `lol` to 1 in the cycle after that window ends.
- R4: The tolerance is tol = floor(exp_count * 2000 / 1000000). A window is in tolerance when its count c satisfies exp_count - tol <= c <= exp_count + tol, with both bounds inclusive. Any other count sets `lol` to 1 at the end of that window.
- R5: `lol` falls only at the end of a window, and only when that window and the window before it were both in tolerance. A single good window after a bad one leaves `lol` at 1.
- R6: With `gate_sync_en` at 0, `sync_disable` stays 0 whatever the state of `lol`, so synchronous outputs keep running freely.
- R7: With `gate_sync_en` at 1, `sync_disable` equals `lol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local timebase clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Monitored reference clock, asynchronous to clk |
| exp_count | input | CNT_W | Expected reference edges per window |
| gate_sync_en | input | 1 | 1: request disable of synchronous outputs while lock is lost |
| lol | output | 1 | Loss-of-lock flag, 1 when lock is lost |
| sync_disable | output | 1 | Request to hold synchronous outputs in their disabled state |

## Verification
The hard cases to reach are counts that sit exactly on, or one past, the edges of the tolerance band. Forming these by bending the reference period would depend on how each window's edges fall against the window boundaries. Instead, the reference is held at a fixed period that divides the window exactly, so every steady window holds the same count. The expected count is then stepped to the values that place that count on each bound and one beyond it. The hysteresis case is timed from the rising edge of `lol`, which marks a window boundary. The expected count is restored at that boundary, and the flag is checked after one good window and again after two.

// File: rtl/ref_lock_monitor.sv
`timescale 1ns/1ps
module ref_lock_monitor #(
  parameter int WIN_LEN = 8192,
  parameter int CNT_W   = 16,
  parameter int PPM     = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic [CNT_W-1:0] exp_count,
  input  logic             gate_sync_en,
  output logic             lol,
  output logic             sync_disable
);
  localparam int WC_W   = $clog2(WIN_LEN);
  localparam int PROD_W = CNT_W + 24;
  localparam logic [WC_W-1:0] WIN_LAST = WC_W'(WIN_LEN - 1);

  logic [2:0]        sync_q;
  logic [WC_W-1:0]   win_q;
  logic [CNT_W-1:0]  edge_q;
  logic [CNT_W-1:0]  meas;
  logic [PROD_W-1:0] prod;
  logic [CNT_W-1:0]  tol;
  logic [CNT_W:0]    lo_b, hi_b;
  logic              ref_edge, win_end, in_tol, good_run;

  assign ref_edge = sync_q[1] & ~sync_q[2];
  assign win_end  = (win_q == WIN_LAST);
  assign meas     = (ref_edge && edge_q != '1) ? edge_q + 1'b1 : edge_q;
  assign prod     = PROD_W'(exp_count) * PROD_W'(PPM);
  assign tol      = CNT_W'(prod / PROD_W'(1000000));
  assign lo_b     = {1'b0, exp_count} - {1'b0, tol};
  assign hi_b     = {1'b0, exp_count} + {1'b0, tol};
  assign in_tol   = (meas != '0) && ({1'b0, meas} >= lo_b) && ({1'b0, meas} <= hi_b);
  assign sync_disable = lol & gate_sync_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], ref_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      edge_q <= '0;
    end else if (win_end) begin
      win_q  <= '0;
      edge_q <= '0;
    end else begin
      win_q  <= win_q + 1'b1;
      edge_q <= meas;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lol      <= 1'b1;
      good_run <= 1'b0;
    end else if (win_end) begin
      if (!in_tol) begin
        lol      <= 1'b1;
        good_run <= 1'b0;
      end else if (good_run) begin
        lol      <= 1'b0;
      end else begin
        good_run <= 1'b1;
      end
    end
  end
endmodule

module ref_lock_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic lol,
  input logic sync_disable,
  input logic gate_sync_en,
  input logic win_end,
  input logic good_run
);
  AST_RESET_FLAG: assert property (@(posedge clk) disable iff (!rst_n) !$past(rst_n) |-> lol); // R1
  AST_RISE_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(lol) |-> $past(win_end)); // R4
  AST_FALL_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) $fell(lol) |-> $past(win_end)); // R5
  AST_FALL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) $fell(lol) |-> $past(good_run)); // R5
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n) !gate_sync_en |-> !sync_disable); // R6
  AST_GATE_NEEDS_LOL: assert property (@(posedge clk) disable iff (!rst_n) sync_disable |-> lol); // R7
endmodule

bind ref_lock_monitor ref_lock_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lol(lol), .sync_disable(sync_disable),
  .gate_sync_en(gate_sync_en), .win_end(win_end), .good_run(good_run)
);

// File: tb/ref_lock_monitor_bench.sv
`timescale 1ns/1ps
module ref_lock_monitor_bench;
  localparam int WIN = 2048;
  localparam int CW  = 16;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, ref_run = 1'b0;
  logic [CW-1:0] exp_count = 16'd512;
  logic gate_sync_en = 1'b0;
  logic lol, sync_disable;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // entry: {exp_count[17:2], gate[1], expected lol[0]}; reference gives 512 edges per window, tol = 1
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {16'd512, 1'b0, 1'b0},
    {16'd513, 1'b0, 1'b0},
    {16'd514, 1'b0, 1'b1},
    {16'd511, 1'b0, 1'b0},
    {16'd510, 1'b0, 1'b1},
    {16'd512, 1'b1, 1'b0},
    {16'd520, 1'b1, 1'b1},
    {16'd520, 1'b0, 1'b1}
  };

  ref_lock_monitor #(.WIN_LEN(WIN), .CNT_W(CW)) u_ref_lock_monitor (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .exp_count(exp_count),
    .gate_sync_en(gate_sync_en), .lol(lol), .sync_disable(sync_disable)
  );

  always #10 clk = ~clk;

  initial begin : refgen
    int ph = 0;
    forever begin
      @(negedge clk);
      if (ref_run) begin
        ph = (ph + 1) % 4;
        ref_clk = (ph < 2);
      end else ref_clk = 1'b0;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    ref_run = 1'b1;
    wait_cyc(5);
    chk(lol, 1'b1, "R1 lol in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(lol, 1'b1, "R1 lol right after reset");
    wait_cyc(WIN + WIN/2);
    chk(lol, 1'b1, "R1 lol after one window");
    wait_cyc(WIN + 100);
    chk(lol, 1'b0, "R2 lol after two good windows");
    chk(sync_disable, 1'b0, "R6 no disable when locked");

    for (int v = 0; v < NV; v++) begin
      exp_count    = VEC[v][17:2];
      gate_sync_en = VEC[v][1];
      wait_cyc(3*WIN + 8);
      chk(lol, VEC[v][0], $sformatf("R4 vector %0d lol", v));
      if (VEC[v][1])
        chk(sync_disable, VEC[v][0], $sformatf("R7 vector %0d sync_disable", v));
      else
        chk(sync_disable, 1'b0, $sformatf("R6 vector %0d sync_disable", v));
    end

    exp_count = 16'd512; gate_sync_en = 1'b1;
    wait_cyc(3*WIN);
    chk(lol, 1'b0, "R2 relocked before missing test");
    ref_run = 1'b0;
    wait_cyc(2*WIN + 8);
    chk(lol, 1'b1, "R3 lol with reference removed");
    chk(sync_disable, 1'b1, "R7 disable with reference removed");
    ref_run = 1'b1;
    wait_cyc(3*WIN + 8);
    chk(lol, 1'b0, "R2 lol after reference returns");

    exp_count = 16'd514;
    begin : waitrise
      for (int i = 0; i < 2*WIN + 8; i++) begin
        @(negedge clk);
        if (lol) disable waitrise;
      end
    end
    chk(lol, 1'b1, "R4 lol rises on bad window");
    exp_count = 16'd512;
    wait_cyc(WIN + 8);
    chk(lol, 1'b1, "R5 one good window keeps lol");
    wait_cyc(WIN);
    chk(lol, 1'b0, "R5 second good window clears lol");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule